// File: doc/BRIEF.md
# Buffered PWM Timer

A single-channel pulse-width generator with a small write/read register port. Software programs the width of the low part of each period and the period length, both counted in input clock cycles, then writes a control word. A counter runs on the input clock and drives one output pin. The pin is low for the first part of each period and high for the rest. The control word sets single-pulse mode, output inversion, an active-low pin-driver enable, a counter restart, and an end-of-period interrupt with a sticky flag.

Width and period writes go into buffer registers. The counter compares against a separate active copy of both values. That copy follows the buffers while the block is disabled and is refreshed only at a period wrap while it runs, so a period never mixes old and new settings. Two further control bits (capture enable, dead-zone enable) can be written and read back but have no effect.

Top module: `pwm_timer`

## Requirements
- R1: After reset all registers read 0, `pwm_o` is 0, `irq_o` is 0 and `oe_no` is 0.
- R2: Offset 0x4 holds the low-width buffer, 0x8 the period buffer and 0xC the control word; a write to an offset is visible on `rdata_o` when `addr_i` selects it. Control bits 8 and 10 are stored and read back, with no effect on `pwm_o`.
- R3: Control bit 0 enables the counter. After the cycle that sets it, the count steps 0,1,…,P-1 and then wraps to 0. The raw output is low while count < D and high while count >= D, with D the low width and P the period.
- R4: A low width of D >= P gives a constantly low raw output. A low width of D = 0 gives a constantly high raw output.
- R5: Control bit 9 inverts the raw output while enabled.
- R6: While bit 0 is 0, `pwm_o` is 0 whatever the inversion bit holds.
- R7: While running, new buffer values take effect only at the next period wrap; the period in progress completes with the old values.
- R8: With control bit 4 set, the block clears bit 0 at the end of the first complete period. `pwm_o` then stays 0.
- R9: Bit 6 is a sticky flag set at each period wrap while bit 5 (interrupt enable) is 1. Writing 1 to bit 6 clears it. `irq_o` equals the flag ANDed with bit 5.
- R10: Writing 1 to bit 7 zeroes the counter on the next cycle. Bit 7 reads back as 0.
- R11: `oe_no` follows control bit 3 (0 = pin driven).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Counter and register clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 4 | Register byte offset |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i` |
| pwm_o | output | 1 | Pulse output |
| oe_no | output | 1 | Pin driver enable, active low |
| irq_o | output | 1 | End-of-period interrupt |

## Verification
The bench compares the pin against a per-cycle expected waveform. It targets the first count after enable, where an off-by-one start shifts every edge by a cycle. It rewrites the low width in the middle of a period: a design without working buffers changes the pulse shape before the wrap. It covers low widths of 0 and at or above the period, where a wrong comparison leaves a one-cycle glitch. In single-pulse mode a missed stop shows up as a second pulse. The counter restart must land exactly one cycle after the write. The interrupt flag must survive disabling and clear only on a write of 1.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;
  localparam int unsigned REG_AW = 4;

  localparam logic [REG_AW-1:0] OFS_LOW  = 4'h4;
  localparam logic [REG_AW-1:0] OFS_PER  = 4'h8;
  localparam logic [REG_AW-1:0] OFS_CTRL = 4'hC;

  localparam int unsigned B_EN   = 0;
  localparam int unsigned B_OEN  = 3;
  localparam int unsigned B_ONE  = 4;
  localparam int unsigned B_IE   = 5;
  localparam int unsigned B_IF   = 6;
  localparam int unsigned B_CRST = 7;
  localparam int unsigned B_CAP  = 8;
  localparam int unsigned B_INV  = 9;
  localparam int unsigned B_DZ   = 10;

  typedef struct packed {
    logic dz;
    logic inv;
    logic cap;
    logic ie;
    logic one;
    logic oe_n;
    logic en;
  } ctrl_t;
endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
  import pwm_timer_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 16
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  we_i,
  input  logic [REG_AW-1:0]     addr_i,
  input  logic [DATA_W-1:0]     wdata_i,
  input  logic                  wrap_i,
  input  logic                  clr_en_i,
  output logic [DATA_W-1:0]     rdata_o,
  output ctrl_t                 ctrl_o,
  output logic                  flag_o,
  output logic                  rst_req_o,
  output logic                  ctrl_wr_o,
  output logic [CNT_W-1:0]      low_buf_o,
  output logic [CNT_W-1:0]      per_buf_o
);
  ctrl_t            ctrl_q;
  logic             flag_q, rst_req_q;
  logic [CNT_W-1:0] low_q, per_q;
  logic             ctrl_wr;
  logic             unused_wdata;

  assign ctrl_wr      = we_i && (addr_i == OFS_CTRL);
  assign unused_wdata = ^{wdata_i[DATA_W-1:CNT_W], wdata_i[2:1]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q    <= '0;
      flag_q    <= 1'b0;
      rst_req_q <= 1'b0;
      low_q     <= '0;
      per_q     <= '0;
    end else begin
      rst_req_q <= 1'b0;
      // single-pulse stop; a control write in the same cycle overrides it
      if (clr_en_i) ctrl_q.en <= 1'b0;
      if (we_i) begin
        case (addr_i)
          OFS_LOW: low_q <= wdata_i[CNT_W-1:0];
          OFS_PER: per_q <= wdata_i[CNT_W-1:0];
          OFS_CTRL: begin
            ctrl_q.en   <= wdata_i[B_EN];
            ctrl_q.oe_n <= wdata_i[B_OEN];
            ctrl_q.one  <= wdata_i[B_ONE];
            ctrl_q.ie   <= wdata_i[B_IE];
            ctrl_q.cap  <= wdata_i[B_CAP];
            ctrl_q.inv  <= wdata_i[B_INV];
            ctrl_q.dz   <= wdata_i[B_DZ];
            rst_req_q   <= wdata_i[B_CRST];
          end
          default: ;
        endcase
      end
      // set beats clear
      if (wrap_i && ctrl_q.ie)               flag_q <= 1'b1;
      else if (ctrl_wr && wdata_i[B_IF])     flag_q <= 1'b0;
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      OFS_LOW: rdata_o = DATA_W'(low_q);
      OFS_PER: rdata_o = DATA_W'(per_q);
      OFS_CTRL: begin
        rdata_o[B_EN]  = ctrl_q.en;
        rdata_o[B_OEN] = ctrl_q.oe_n;
        rdata_o[B_ONE] = ctrl_q.one;
        rdata_o[B_IE]  = ctrl_q.ie;
        rdata_o[B_IF]  = flag_q;
        rdata_o[B_CAP] = ctrl_q.cap;
        rdata_o[B_INV] = ctrl_q.inv;
        rdata_o[B_DZ]  = ctrl_q.dz;
      end
      default: ;
    endcase
  end

  assign ctrl_o    = ctrl_q;
  assign flag_o    = flag_q;
  assign rst_req_o = rst_req_q;
  assign ctrl_wr_o = ctrl_wr;
  assign low_buf_o = low_q;
  assign per_buf_o = per_q;
endmodule

// File: rtl/pwm_core.sv
module pwm_core #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             one_i,
  input  logic             rst_req_i,
  input  logic [CNT_W-1:0] low_buf_i,
  input  logic [CNT_W-1:0] per_buf_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] act_low_o,
  output logic [CNT_W-1:0] act_per_o,
  output logic             wrap_o,
  output logic             clr_en_o
);
  logic [CNT_W-1:0] cnt_q, act_low_q, act_per_q;
  logic [CNT_W:0]   cnt_nxt;
  logic             wrap;

  assign cnt_nxt = {1'b0, cnt_q} + 1'b1;
  // period 0 behaves like period 1
  assign wrap    = en_i && !rst_req_i && (cnt_nxt >= {1'b0, act_per_q});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      act_low_q <= '0;
      act_per_q <= '0;
    end else if (!en_i) begin
      cnt_q     <= '0;
      act_low_q <= low_buf_i;
      act_per_q <= per_buf_i;
    end else if (rst_req_i) begin
      cnt_q <= '0;
    end else if (wrap) begin
      cnt_q     <= '0;
      act_low_q <= low_buf_i;
      act_per_q <= per_buf_i;
    end else begin
      cnt_q <= cnt_nxt[CNT_W-1:0];
    end
  end

  assign cnt_o     = cnt_q;
  assign act_low_o = act_low_q;
  assign act_per_o = act_per_q;
  assign wrap_o    = wrap;
  assign clr_en_o  = wrap && one_i;
endmodule

// File: rtl/pwm_shaper.sv
module pwm_shaper #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             en_i,
  input  logic             inv_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] low_i,
  output logic             pwm_o
);
  logic raw;
  assign raw   = (cnt_i >= low_i);
  assign pwm_o = en_i && (raw ^ inv_i);
endmodule

// File: rtl/pwm_timer.sv
module pwm_timer
  import pwm_timer_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [3:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              pwm_o,
  output logic              oe_no,
  output logic              irq_o
);
  ctrl_t            ctrl;
  logic             flag, rst_req, ctrl_wr, wrap, clr_en;
  logic [CNT_W-1:0] low_buf, per_buf, cnt, act_low, act_per;

  pwm_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W)) i_regs (
    .clk_i, .rst_ni, .we_i, .addr_i, .wdata_i,
    .wrap_i(wrap), .clr_en_i(clr_en), .rdata_o,
    .ctrl_o(ctrl), .flag_o(flag), .rst_req_o(rst_req), .ctrl_wr_o(ctrl_wr),
    .low_buf_o(low_buf), .per_buf_o(per_buf)
  );

  pwm_core #(.CNT_W(CNT_W)) i_core (
    .clk_i, .rst_ni, .en_i(ctrl.en), .one_i(ctrl.one), .rst_req_i(rst_req),
    .low_buf_i(low_buf), .per_buf_i(per_buf),
    .cnt_o(cnt), .act_low_o(act_low), .act_per_o(act_per),
    .wrap_o(wrap), .clr_en_o(clr_en)
  );

  pwm_shaper #(.CNT_W(CNT_W)) i_shaper (
    .en_i(ctrl.en), .inv_i(ctrl.inv), .cnt_i(cnt), .low_i(act_low), .pwm_o
  );

  assign oe_no = ctrl.oe_n;
  assign irq_o = flag && ctrl.ie;
endmodule

// File: rtl/pwm_timer_chk.sv
module pwm_timer_chk #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             pwm_o,
  input logic             irq_o,
  input logic             en,
  input logic             ie,
  input logic             one,
  input logic             flag,
  input logic             rst_req,
  input logic             ctrl_wr,
  input logic             wrap,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] act_low,
  input logic [CNT_W-1:0] act_per
);
  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en && act_per != '0) |-> (cnt < act_per)); // R3
  AST_DISABLED_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en |-> !pwm_o); // R6
  AST_ACT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en && $past(en) && !$past(wrap)) |-> ($stable(act_low) && $stable(act_per))); // R7
  AST_SINGLE_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wrap && one && !ctrl_wr) |=> !en); // R8
  AST_FLAG_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wrap && ie) |=> flag); // R9
  AST_IRQ_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (ie && flag)); // R9
  AST_CNT_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req |=> (cnt == '0)); // R10
endmodule

bind pwm_timer pwm_timer_chk #(.CNT_W(CNT_W)) i_chk (
  .clk_i, .rst_ni, .pwm_o, .irq_o,
  .en(ctrl.en), .ie(ctrl.ie), .one(ctrl.one), .flag(flag), .rst_req(rst_req),
  .ctrl_wr(ctrl_wr), .wrap(wrap), .cnt(cnt), .act_low(act_low), .act_per(act_per)
);

// File: tb/test_pwm_timer.sv
module test_pwm_timer;
  localparam logic [3:0] A_LOW = 4'h4, A_PER = 4'h8, A_CTRL = 4'hC;

  typedef struct {
    logic  val;
    string tag;
  } exp_t;

  logic        clk = 1'b0, rst_n = 1'b0, we = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic        pwm, oe_n, irq;
  int          checks = 0, errors = 0;
  exp_t        q[$];
  exp_t        e;

  always #4 clk = ~clk;

  pwm_timer i_pwm_timer (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .pwm_o(pwm), .oe_no(oe_n), .irq_o(irq)
  );

  // monitor: one expected pin value per cycle
  always @(negedge clk) begin
    if (q.size() > 0) begin
      e = q.pop_front();
      checks++;
      if (pwm !== e.val) begin
        errors++;
        $display("FAIL %s pwm_o got %b exp %b at %0t", e.tag, pwm, e.val, $time);
      end
    end
  end

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s got %h exp %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    #1;
    we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic push(input string tag, input logic v);
    exp_t x;
    x.val = v; x.tag = tag;
    q.push_back(x);
  endtask

  task automatic push_wave(input string tag, input int n, input int d, input int p,
                           input logic inv);
    for (int j = 0; j < n; j++) push(tag, ((j % p) >= d) ^ inv);
  endtask

  task automatic drain();
    wait (q.size() == 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 pwm_o", {31'd0, pwm}, 0);
    chk("R1 irq_o", {31'd0, irq}, 0);
    chk("R1 oe_no", {31'd0, oe_n}, 0);
    rd(A_CTRL, r); chk("R1 ctrl", r, 0);
    rd(A_LOW, r);  chk("R1 low", r, 0);
    rd(A_PER, r);  chk("R1 per", r, 0);

    // R2 register map
    wr(A_LOW, 3); wr(A_PER, 8);
    rd(A_LOW, r); chk("R2 low", r, 3);
    rd(A_PER, r); chk("R2 per", r, 8);

    // R3 basic waveform
    wr(A_CTRL, 32'h1);
    push_wave("R3", 16, 3, 8, 1'b0);
    drain();
    wr(A_CTRL, 32'h0);

    // R6 disabled with inversion set
    wr(A_CTRL, 32'h200);
    for (int j = 0; j < 4; j++) push("R6", 1'b0);
    drain();

    // R5 inversion, R2 reserved bits stored without effect
    wr(A_LOW, 2); wr(A_PER, 5);
    wr(A_CTRL, 32'h701);
    push_wave("R5", 10, 2, 5, 1'b1);
    drain();
    rd(A_CTRL, r); chk("R2 reserved readback", r, 32'h701);
    wr(A_CTRL, 32'h0);

    // R4 low width at or above period, and zero
    wr(A_LOW, 6); wr(A_PER, 4);
    wr(A_CTRL, 32'h1);
    for (int j = 0; j < 8; j++) push("R4 D>=P", 1'b0);
    drain();
    wr(A_CTRL, 32'h0);
    wr(A_LOW, 0);
    wr(A_CTRL, 32'h1);
    for (int j = 0; j < 8; j++) push("R4 D=0", 1'b1);
    drain();
    wr(A_CTRL, 32'h0);

    // R7 buffered update mid-period
    wr(A_LOW, 3); wr(A_PER, 8);
    wr(A_CTRL, 32'h1);
    for (int j = 0; j < 24; j++) push("R7", (j < 8) ? (j >= 3) : ((j % 8) >= 5));
    wr(A_LOW, 5);
    drain();
    wr(A_CTRL, 32'h0);

    // R8 single pulse
    wr(A_LOW, 2); wr(A_PER, 4);
    wr(A_CTRL, 32'h11);
    push_wave("R8", 4, 2, 4, 1'b0);
    for (int j = 0; j < 6; j++) push("R8 stopped", 1'b0);
    drain();
    rd(A_CTRL, r); chk("R8 enable cleared", r, 32'h10);
    wr(A_CTRL, 32'h0);

    // R10 counter restart one cycle after the write
    wr(A_LOW, 4); wr(A_PER, 10);
    wr(A_CTRL, 32'h1);
    for (int j = 0; j < 20; j++) begin
      int c;
      c = (j < 2) ? j : ((j - 2) % 10);
      push("R10", c >= 4);
    end
    wr(A_CTRL, 32'h81);
    drain();
    rd(A_CTRL, r); chk("R10 self-clear", r, 32'h1);
    wr(A_CTRL, 32'h0);

    // R9 interrupt
    wr(A_LOW, 1); wr(A_PER, 4);
    wr(A_CTRL, 32'h1);
    repeat (10) @(negedge clk);
    chk("R9 irq with ie=0", {31'd0, irq}, 0);
    rd(A_CTRL, r); chk("R9 flag with ie=0", r, 32'h1);
    wr(A_CTRL, 32'h21);
    repeat (6) @(negedge clk);
    chk("R9 irq set", {31'd0, irq}, 1);
    rd(A_CTRL, r); chk("R9 flag bit6", r & 32'h40, 32'h40);
    wr(A_CTRL, 32'h20);
    repeat (3) @(negedge clk);
    chk("R9 flag sticky", {31'd0, irq}, 1);
    wr(A_CTRL, 32'h60);
    @(negedge clk);
    chk("R9 irq cleared", {31'd0, irq}, 0);
    rd(A_CTRL, r); chk("R9 ctrl after clear", r, 32'h20);

    // R11 pin driver enable
    wr(A_CTRL, 32'h8);
    @(negedge clk);
    chk("R11 oe_no high", {31'd0, oe_n}, 1);
    wr(A_CTRL, 32'h0);
    @(negedge clk);
    chk("R11 oe_no low", {31'd0, oe_n}, 0);

    summary();
    $finish;
  end
endmodule